// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block chooses where a real-time clock gets its slow clock from. It can pick the internal RC oscillator, which has been divided down by a prescaler before it arrives here. It can instead pick an external 32 kHz crystal oscillator. Software controls the choice through one 32-bit control word. A write changes that word only when its upper half carries an unlock key. This protects against stray writes.

The chosen source drives a clock multiplexer that switches without glitches. Each clock domain has its own synchronizer. The two synchronizers hand the output over so that one clock's gate has fully closed before the other clock's gate opens.

A failure-detect input, `ext_fail`, can force the block back to the internal source on its own. It is synchronous to the register clock. When this fallback happens, a sticky status bit records it. Software can set a bypass bit to turn the automatic fallback off. The same failure input also closes the external gate of the multiplexer asynchronously. This lets the handover complete even when the crystal has stopped.

Top module: `osc_sel_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0, `src_sel` is 0 (internal source) and `ext_osc_en` is 0.
- R2: A write with 16'h16AA in bits [31:16] updates the control fields from the next cycle. Bit 0 is the source select (1 = external). Bit 1 is the external oscillator enable. Bit 2 is the fallback bypass.
- R3: A write whose bits [31:16] hold any value other than 16'h16AA leaves the whole control word unchanged.
- R4: Bits [31:4] of `rd_data` always read 0. Bits [3:0] read back status, bypass, enable and select, in that order from bit 3 down to bit 0.
- R5: When `ext_fail` is high, select is 1 and bypass is 0, the next cycle shows select 0 and status bit 3 set. This takes priority over a keyed write in the same cycle. When select is 0, `ext_fail` changes nothing in the control word.
- R6: With bypass set, `ext_fail` changes neither select nor status.
- R7: The status bit stays set until a keyed write carries 1 in bit 3. A keyed write with 0 in bit 3 leaves it set. A fallback in the same cycle as the clearing write wins, and status stays set.
- R8: Once the handover has settled, `lsclk` follows the internal clock when select is 0 and the external clock when select is 1. The two source gates are never open at the same time.
- R9: No high or low phase on `lsclk` is shorter than the shorter half period of the two source clocks, including across source changes.
- R10: While `ext_fail` is high, the external gate is held closed asynchronously. A switch back to the internal clock therefore completes with the external clock stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data: key in [31:16], fields in [3:0] |
| ext_fail | input | 1 | External oscillator failure flag, synchronous to `clk` |
| int_clk | input | 1 | Internal RC oscillator after the prescaler |
| ext_clk | input | 1 | External crystal oscillator |
| rd_data | output | 32 | Control word readback |
| src_sel | output | 1 | Registered source select (1 = external) |
| ext_osc_en | output | 1 | External oscillator power enable |
| lsclk | output | 1 | Glitch-free selected low-speed clock |

## Verification
The hardest case to reach is the fallback path itself. The external clock really stops, and the handover back to the internal clock must then finish with no edges from the dead domain. The stimulus can gate off the external clock generator at a low phase before it raises `ext_fail`. It then checks `lsclk` against the internal clock on that clock's own edges. A second awkward case is a failure that arrives in the same cycle as a keyed write that clears status and requests the external source. The stimulus lines the failure and that write up on one edge to exercise this priority. Throughout the run, a monitor measures every phase width of `lsclk`. This catches any pulse truncated during a handover.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;

  localparam int          DATA_W    = 32;
  localparam int          KEY_W     = 16;
  localparam int          FIELD_W   = 4;
  localparam logic [15:0] UNLOCK    = 16'h16AA;

  // Control fields, bit 3 down to bit 0 of the word.
  typedef struct packed {
    logic fb_stat;
    logic bypass;
    logic ext_en;
    logic sel_ext;
  } ctl_t;

  function automatic logic key_ok(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: KEY_W] == UNLOCK;
  endfunction

  function automatic logic [DATA_W-1:0] pack_rd(input ctl_t c);
    return {{(DATA_W-FIELD_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/osc_sel_regs.sv
module osc_sel_regs
  import osc_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_fail,
  output ctl_t              ctl,
  output logic              key_match,
  output logic              fb_evt
);

  ctl_t ctl_d;
  ctl_t wr_f;

  assign wr_f      = ctl_t'(wr_data[FIELD_W-1:0]);
  assign key_match = wr_en & key_ok(wr_data);
  assign fb_evt    = ctl.sel_ext & ext_fail & ~ctl.bypass;

  always_comb begin
    ctl_d = ctl;
    if (key_match) begin
      ctl_d.sel_ext = wr_f.sel_ext;
      ctl_d.ext_en  = wr_f.ext_en;
      ctl_d.bypass  = wr_f.bypass;
      ctl_d.fb_stat = ctl.fb_stat & ~wr_f.fb_stat;
    end
    if (fb_evt) begin
      ctl_d.sel_ext = 1'b0;
      ctl_d.fb_stat = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_d;
  end

endmodule

// File: rtl/osc_sel_clkmux.sv
module osc_sel_clkmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic rst_n,
  input  logic ext_fail,
  input  logic sel_ext,
  output logic int_gate,
  output logic ext_gate,
  output logic lsclk
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] i_sync;
  logic [LAST:0] e_sync;
  logic          i_req;
  logic          e_req;
  logic          e_rst_n;

  // A domain may request only while every stage of the other is clear.
  assign i_req   = ~sel_ext & ~(|e_sync);
  assign e_req   =  sel_ext & ~(|i_sync);
  assign e_rst_n = rst_n & ~ext_fail;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(negedge int_clk or negedge rst_n) begin
        if (!rst_n) i_sync <= '0;
        else        i_sync <= {i_sync[LAST-1:0], i_req};
      end
      always_ff @(negedge ext_clk or negedge e_rst_n) begin
        if (!e_rst_n) e_sync <= '0;
        else          e_sync <= {e_sync[LAST-1:0], e_req};
      end
    end else begin : g_single
      always_ff @(negedge int_clk or negedge rst_n) begin
        if (!rst_n) i_sync <= '0;
        else        i_sync <= i_req;
      end
      always_ff @(negedge ext_clk or negedge e_rst_n) begin
        if (!e_rst_n) e_sync <= '0;
        else          e_sync <= e_req;
      end
    end
  endgenerate

  assign int_gate = i_sync[LAST];
  assign ext_gate = e_sync[LAST];
  assign lsclk    = (int_clk & int_gate) | (ext_clk & ext_gate);

endmodule

// File: rtl/osc_sel_ctrl.sv
module osc_sel_ctrl
  import osc_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_fail,
  input  logic              int_clk,
  input  logic              ext_clk,
  output logic [DATA_W-1:0] rd_data,
  output logic              src_sel,
  output logic              ext_osc_en,
  output logic              lsclk
);

  ctl_t ctl;
  logic key_match;
  logic fb_evt;
  logic int_gate;
  logic ext_gate;

  osc_sel_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ext_fail  (ext_fail),
    .ctl       (ctl),
    .key_match (key_match),
    .fb_evt    (fb_evt)
  );

  osc_sel_clkmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .int_clk  (int_clk),
    .ext_clk  (ext_clk),
    .rst_n    (rst_n),
    .ext_fail (ext_fail),
    .sel_ext  (ctl.sel_ext),
    .int_gate (int_gate),
    .ext_gate (ext_gate),
    .lsclk    (lsclk)
  );

  assign rd_data    = pack_rd(ctl);
  assign src_sel    = ctl.sel_ext;
  assign ext_osc_en = ctl.ext_en;

endmodule

// File: rtl/osc_sel_chk.sv
module osc_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        ext_fail,
  input logic [31:0] rd_data,
  input logic        src_sel,
  input logic        key_match,
  input logic        fb_evt,
  input logic        int_gate,
  input logic        ext_gate
);

  p_key_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_match && !fb_evt) |=> $stable(rd_data));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:4] == 28'd0);

  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_evt |=> (!src_sel && rd_data[3]));

  p_bypass_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && rd_data[2] && ext_fail && !key_match) |=> (src_sel && $stable(rd_data[3])));

  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && !(key_match && wr_data[3])) |=> rd_data[3]);

  p_gate_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_gate && ext_gate));

endmodule

bind osc_sel_ctrl osc_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ext_fail  (ext_fail),
  .rd_data   (rd_data),
  .src_sel   (src_sel),
  .key_match (key_match),
  .fb_evt    (fb_evt),
  .int_gate  (int_gate),
  .ext_gate  (ext_gate)
);

// File: tb/osc_sel_ctrl_bench.sv
`timescale 1ns/1ps
module osc_sel_ctrl_bench;

  localparam real CLK_PERIOD = 10.0;
  localparam real INT_HALF   = 7.0;
  localparam real EXT_HALF   = 11.0;
  localparam logic [15:0] KEY = 16'h16AA;

  logic        clk = 0, rst_n = 0, wr_en = 0, ext_fail = 0;
  logic        int_clk = 0, ext_clk = 0, ext_run = 1;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        src_sel, ext_osc_en, lsclk;

  int  nvec = 0, nerr = 0;
  real last_edge = -1.0, min_phase = 1.0e9;

  osc_sel_ctrl u_osc_sel_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_fail(ext_fail), .int_clk(int_clk), .ext_clk(ext_clk),
    .rd_data(rd_data), .src_sel(src_sel), .ext_osc_en(ext_osc_en),
    .lsclk(lsclk)
  );

  always #(CLK_PERIOD/2.0) clk = ~clk;
  always #(INT_HALF) int_clk = ~int_clk;
  always #(EXT_HALF) ext_clk = ext_run ? ~ext_clk : 1'b0;

  // Phase-width monitor for R9.
  always @(lsclk) begin
    if (last_edge >= 0.0 && ($realtime - last_edge) < min_phase)
      min_phase = $realtime - last_edge;
    last_edge = $realtime;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] k, input logic [3:0] f);
    @(negedge clk);
    wr_en = 1; wr_data = {k, 12'h0, f};
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic follow(input bit use_ext, input string req);
    for (int i = 0; i < 4; i++) begin
      if (use_ext) @(posedge ext_clk); else @(posedge int_clk);
      #1;
      check(lsclk == 1'b1, req, {31'd0, lsclk}, 32'd1);
      if (use_ext) @(negedge ext_clk); else @(negedge int_clk);
      #1;
      check(lsclk == 1'b0, req, {31'd0, lsclk}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [3:0] cur;
    idle(3);
    // R1: reset state
    check(rd_data == 0 && !src_sel && !ext_osc_en, "R1", rd_data, 0);
    rst_n = 1;
    idle(2);
    check(rd_data == 0 && !src_sel && !ext_osc_en, "R1", rd_data, 0);

    // R2/R4: all keyed combinations of select, enable, bypass
    for (int v = 0; v < 8; v++) begin
      wr(KEY, v[3:0]);
      check(rd_data == 32'(v), "R2", rd_data, 32'(v));
      check(src_sel == v[0] && ext_osc_en == v[1], "R2", {30'd0, ext_osc_en, src_sel}, 32'(v & 3));
      check(rd_data[31:4] == 0, "R4", rd_data, 32'(v));
    end

    // R3: every single-bit key corruption, plus zero and all-ones keys
    wr(KEY, 4'b0101);
    cur = 4'b0101;
    for (int i = 0; i < 18; i++) begin
      logic [15:0] bad;
      bad = (i < 16) ? (KEY ^ (16'd1 << i)) : ((i == 16) ? 16'h0000 : 16'hFFFF);
      wr(bad, ~cur);
      check(rd_data == {28'd0, cur}, "R3", rd_data, {28'd0, cur});
    end

    // R8: settled source follows select
    wr(KEY, 4'b0000);
    idle(20);
    follow(0, "R8");
    wr(KEY, 4'b0011);
    idle(20);
    follow(1, "R8");

    // R5 with select 0: failure has no effect
    wr(KEY, 4'b0000);
    idle(20);
    @(negedge clk); ext_fail = 1;
    @(negedge clk); ext_fail = 0;
    check(rd_data == 0, "R5", rd_data, 0);

    // R6: bypass keeps the external selection through a failure
    wr(KEY, 4'b0111);
    idle(20);
    ext_run = 0; idle(4);
    @(negedge clk); ext_fail = 1;
    idle(3);
    check(rd_data == 32'h7 && src_sel, "R6", rd_data, 32'h7);
    ext_fail = 0; ext_run = 1;
    idle(20);
    follow(1, "R6");

    // R5/R10: fallback with a dead crystal
    wr(KEY, 4'b0011);
    idle(20);
    ext_run = 0; idle(4);
    @(negedge clk); ext_fail = 1;
    @(negedge clk);
    check(rd_data == 32'hA && !src_sel, "R5", rd_data, 32'hA);
    idle(10);
    follow(0, "R10");
    ext_fail = 0;

    // R7: W1C behaviour
    wr(KEY, 4'b0000);
    check(rd_data == 32'h8, "R7", rd_data, 32'h8);
    wr(KEY, 4'b1000);
    check(rd_data == 32'h0, "R7", rd_data, 32'h0);

    // R5/R7: fallback beats a same-cycle clear and select write
    wr(KEY, 4'b0011);
    idle(3);
    @(negedge clk);
    ext_fail = 1; wr_en = 1; wr_data = {KEY, 12'h0, 4'b1011};
    @(negedge clk);
    ext_fail = 0; wr_en = 0; wr_data = 0;
    check(rd_data == 32'hA && !src_sel, "R7", rd_data, 32'hA);

    ext_run = 1;
    idle(20);
    follow(0, "R8");

    // R9: no short phases anywhere in the run
    check(min_phase >= INT_HALF - 0.01, "R9", 32'($rtoi(min_phase)), 32'($rtoi(INT_HALF)));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule